// File: doc/BRIEF.md
# Message-Object FIFO Pointer Controller

This block turns a run of consecutive message objects of a CAN controller into one FIFO, used either for reception or for transmission. Element 0 is the base of the group. A configuration register sets the direction and the power-of-two FIFO size, and a pointer marks the element currently in use. The protocol engine reports three kinds of event: a frame received for the FIFO, the transmission of the offered element finished, and a remote frame matched to one element. From these the block decides whether the FIFO is enabled, which element is written or offered for sending, how the pointer moves, and which status flags each element gets.

A CPU register port reaches every element directly. Each element has a control register and a data register. The CPU can read the configuration register, and the pointer, at any element address. CPU traffic never moves the pointer, so software handles draining and refilling the FIFO itself. Bit timing, framing, CRC and acceptance filtering are done elsewhere.

Top module: `msgfifo_ctrl`

## Requirements
- R1: After reset the pointer is 0. Every element control register reads 0x0001 (not valid, all flags clear). The configuration register reads receive mode with log2 size equal to log2 of the element count (0x0006 for 8 elements), and `tx_pending` is 0.
- R2: In receive mode (config bit 0 = 0), a frame arrives while the addressed element is valid (control bits [1:0] = 2'b10). The frame data is stored in that element, its new-data flag (control bit 2) is set, and the pointer advances by one.
- R3: Config bits [3:1] hold log2 of the FIFO size. The pointer wraps from size-1 to 0, and elements at or above the size take no part in the FIFO.
- R4: A frame arrives while the addressed element is not valid (bits [1:0] = 2'b01), and either the pointer is 0 or the base element is not valid. The frame is ignored: no data or flag changes and the pointer holds.
- R5: A frame arrives while the base element is valid and the addressed element (pointer not 0) is not valid. The frame is not stored in that element, and the pointer still advances.
- R6: Only the addressed element's validity gates a transfer. Invalid elements that are not addressed do not block reception into a valid addressed element.
- R7: The lost-message flag (control bit 3) is set when a received frame is written into an element whose new-data flag is already set. It is not set by a write into an element whose new-data flag is clear.
- R8: In transmit mode (config bit 0 = 1), `tx_pending` is 1 with `tx_idx`/`tx_data` showing the addressed element when that element is valid and has its transmit-request flag (control bit 4) set. The first element offered is element 0. A `tx_done` pulse clears that element's transmit-request and remote-pending flags (bit 5), and the pointer advances in the same clock edge.
- R9: In transmit mode, `rmt_hit` with `rmt_idx` inside the FIFO sets that element's transmit-request and remote-pending flags. The element is then sent only when the pointer reaches it.
- R10: CPU reads and writes, including writes to the configuration register and to element control registers, never change the pointer.
- R11: When a received frame and a CPU write hit the same element in the same cycle, the hardware update wins. The new-data flag ends set and the stored data is the frame data.
- R12: In transmit mode, if the addressed element is not valid, `tx_pending` is 0 and `tx_done` has no effect on the pointer or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_en | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU write when set together with `cpu_en` |
| cpu_addr | input | PTR_W+2 | {element index, register select}: select 0 control, 1 data, 2 configuration |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data for `cpu_addr`; the configuration read carries the pointer in bits [15:8] |
| rx_valid | input | 1 | One-cycle pulse: frame received for the FIFO |
| rx_data | input | DATA_W | Received frame payload |
| tx_done | input | 1 | One-cycle pulse: the offered element has been transmitted |
| tx_pending | output | 1 | Addressed element is ready to send |
| tx_idx | output | PTR_W | Index of the offered element |
| tx_data | output | DATA_W | Payload of the offered element |
| rmt_hit | input | 1 | One-cycle pulse: remote frame matched an element |
| rmt_idx | input | PTR_W | Element matched by the remote frame |
| fifo_ptr | output | PTR_W | Current pointer |

## Verification
The bench targets the validity corner cases. Consider a frame aimed at an invalid slave while the base is valid. A design that skips the pointer step would stall there, and one that writes anyway would corrupt the slave's data. An invalid element that is not addressed must not block reception, and a design that checks every element would freeze. The bench also targets overrun, same-cycle CPU/engine collisions, and pointer wrap at a configured size smaller than the element count. Wrong handling shows up as a missing or spurious lost flag, a cleared new-data flag, or a pointer that runs past the FIFO end. In transmit mode, a remote request placed ahead of the pointer must wait its turn. A `tx_done` aimed at an invalid element must leave the pointer where it is.

// File: rtl/msgfifo_pkg.sv
package msgfifo_pkg;

  localparam logic [1:0] VLD_ON  = 2'b10;
  localparam logic [1:0] VLD_OFF = 2'b01;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // control register image, bit 5 down to bit 0
  typedef struct packed {
    logic       rmt_pend;
    logic       tx_req;
    logic       lost;
    logic       new_dat;
    logic [1:0] vld;
  } obj_ctrl_t;

  function automatic logic is_valid(input logic [1:0] v);
    return v == VLD_ON;
  endfunction

  // mask of pointer bits in use for a FIFO of 2**lg elements, clamped to pw
  function automatic logic [7:0] slot_mask(input logic [2:0] lg, input int unsigned pw);
    logic [2:0] l;
    l = (32'(lg) > pw) ? 3'(pw) : lg;
    return 8'((9'd1 << l) - 9'd1);
  endfunction

  function automatic logic [7:0] next_slot(input logic [7:0] p, input logic [7:0] m);
    return (p + 8'd1) & m;
  endfunction

endpackage

// File: rtl/mf_obj_slot.sv
module mf_obj_slot
  import msgfifo_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ctrl_we,
  input  logic              cpu_data_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              hw_rx_we,
  input  logic [DATA_W-1:0] hw_rx_data,
  input  logic              hw_tx_clr,
  input  logic              hw_rmt_set,
  output obj_ctrl_t         ctrl_o,
  output logic [DATA_W-1:0] data_o
);

  obj_ctrl_t         ctrl_q, ctrl_d;
  logic [DATA_W-1:0] data_q, data_d;

  // CPU write first, engine updates layered on top so they win
  always_comb begin
    ctrl_d = ctrl_q;
    data_d = data_q;
    if (cpu_ctrl_we) ctrl_d = obj_ctrl_t'(cpu_wdata[5:0]);
    if (cpu_data_we) data_d = cpu_wdata;
    if (hw_rx_we) begin
      data_d         = hw_rx_data;
      ctrl_d.new_dat = 1'b1;
      ctrl_d.lost    = ctrl_d.lost | ctrl_q.new_dat;
    end
    if (hw_tx_clr) begin
      ctrl_d.tx_req   = 1'b0;
      ctrl_d.rmt_pend = 1'b0;
    end
    if (hw_rmt_set) begin
      ctrl_d.tx_req   = 1'b1;
      ctrl_d.rmt_pend = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{rmt_pend: 1'b0, tx_req: 1'b0, lost: 1'b0, new_dat: 1'b0, vld: VLD_OFF};
      data_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      data_q <= data_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign data_o = data_q;

  assert_rx_sets_newdat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rx_we |=> (ctrl_q.new_dat && data_q == $past(hw_rx_data)));

  assert_overrun_lost_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_rx_we && ctrl_q.new_dat) |=> ctrl_q.lost);

  assert_lost_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.lost) |-> $past(cpu_ctrl_we || (hw_rx_we && ctrl_q.new_dat)));

  assert_hw_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_rx_we && (cpu_ctrl_we || cpu_data_we)) |=> (ctrl_q.new_dat && data_q == $past(hw_rx_data)));

  assert_tx_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_tx_clr && !hw_rmt_set) |=> (!ctrl_q.tx_req && !ctrl_q.rmt_pend));

  assert_remote_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rmt_set |=> (ctrl_q.tx_req && ctrl_q.rmt_pend));

endmodule

// File: rtl/mf_ptr_ctrl.sv
module mf_ptr_ctrl
  import msgfifo_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  localparam int PTR_W  = $clog2(NUM_OBJ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_tx,
  input  logic [2:0]         size_lg,
  input  logic [NUM_OBJ-1:0] obj_ok,
  input  logic [NUM_OBJ-1:0] obj_txrq,
  input  logic               rx_valid,
  input  logic               tx_done,
  input  logic               cpu_busy,
  output logic [PTR_W-1:0]   ptr_o,
  output logic [PTR_W-1:0]   mask_o,
  output logic               rx_we,
  output logic               rx_skip,
  output logic               tx_pend,
  output logic               tx_fire
);

  logic [PTR_W-1:0] ptr_q, ptr_eff, ptr_nxt, mask;
  logic             addr_ok, base_ok, advance;

  assign mask    = PTR_W'(slot_mask(size_lg, PTR_W));
  assign ptr_eff = ptr_q & mask;
  assign ptr_nxt = PTR_W'(next_slot(8'(ptr_eff), 8'(mask)));

  // only the addressed element gates the FIFO
  assign addr_ok = obj_ok[ptr_eff];
  assign base_ok = obj_ok[0];

  assign rx_we   = !mode_tx && rx_valid && addr_ok;
  assign rx_skip = !mode_tx && rx_valid && !addr_ok && (ptr_eff != '0) && base_ok;
  assign tx_pend = mode_tx && addr_ok && obj_txrq[ptr_eff];
  assign tx_fire = tx_pend && tx_done;
  assign advance = rx_we || rx_skip || tx_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (advance) ptr_q <= ptr_nxt;
  end

  assign ptr_o  = ptr_eff;
  assign mask_o = mask;

  assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_we, rx_skip, tx_fire}));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && $stable(size_lg)) |=> ptr_o == PTR_W'((PTR_W'($past(ptr_o)) + PTR_W'(1)) & mask));

  assert_disabled_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !mode_tx && !obj_ok[ptr_o] && (ptr_o == '0 || !obj_ok[0])) |=> $stable(ptr_q));

  assert_skip_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !mode_tx && obj_ok[0] && !obj_ok[ptr_o] && ptr_o != '0) |=> ptr_q != $past(ptr_q));

  assert_cpu_no_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_busy && !rx_valid && !tx_done) |=> $stable(ptr_q));

  assert_tx_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pend |-> (mode_tx && obj_ok[ptr_o]));

endmodule

// File: rtl/mf_reg_port.sv
module mf_reg_port
  import msgfifo_pkg::*;
#(
  parameter int NUM_OBJ  = 8,
  parameter int DATA_W   = 16,
  localparam int PTR_W   = $clog2(NUM_OBJ),
  localparam int ADDR_W  = PTR_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_en,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [3:0]         cfg_wdata,
  input  obj_ctrl_t          ctrl_rd [NUM_OBJ],
  input  logic [DATA_W-1:0]  data_rd [NUM_OBJ],
  input  logic [PTR_W-1:0]   ptr_i,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic [NUM_OBJ-1:0] ctrl_we,
  output logic [NUM_OBJ-1:0] data_we,
  output logic               cfg_tx,
  output logic [2:0]         cfg_lg
);

  reg_sel_e         sel;
  logic [PTR_W-1:0] idx;
  logic             wr;

  assign sel = reg_sel_e'(cpu_addr[1:0]);
  assign idx = cpu_addr[ADDR_W-1:2];
  assign wr  = cpu_en && cpu_we;

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_dec
    assign ctrl_we[i] = wr && (sel == SEL_CTRL) && (idx == PTR_W'(i));
    assign data_we[i] = wr && (sel == SEL_DATA) && (idx == PTR_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_tx <= 1'b0;
      cfg_lg <= 3'(PTR_W);
    end else if (wr && sel == SEL_CFG) begin
      cfg_tx <= cfg_wdata[0];
      cfg_lg <= cfg_wdata[3:1];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: cpu_rdata = DATA_W'(ctrl_rd[idx]);
      SEL_DATA: cpu_rdata = data_rd[idx];
      SEL_CFG:  cpu_rdata = DATA_W'({8'(ptr_i), 4'b0000, cfg_lg, cfg_tx});
      default:  cpu_rdata = '0;
    endcase
  end

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctrl_we, data_we}) <= 1);

endmodule

// File: rtl/msgfifo_ctrl.sv
module msgfifo_ctrl
  import msgfifo_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  parameter int DATA_W  = 16,
  localparam int PTR_W  = $clog2(NUM_OBJ),
  localparam int ADDR_W = PTR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_en,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              tx_done,
  output logic              tx_pending,
  output logic [PTR_W-1:0]  tx_idx,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rmt_hit,
  input  logic [PTR_W-1:0]  rmt_idx,
  output logic [PTR_W-1:0]  fifo_ptr
);

  obj_ctrl_t          ctrl_arr [NUM_OBJ];
  logic [DATA_W-1:0]  data_arr [NUM_OBJ];
  logic [NUM_OBJ-1:0] obj_ok, obj_txrq, ctrl_we, data_we;
  logic [PTR_W-1:0]   ptr, mask;
  logic               cfg_tx, rx_we, rx_skip, tx_fire;
  logic [2:0]         cfg_lg;

  mf_reg_port #(.NUM_OBJ(NUM_OBJ), .DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_en    (cpu_en),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cfg_wdata (cpu_wdata[3:0]),
    .ctrl_rd   (ctrl_arr),
    .data_rd   (data_arr),
    .ptr_i     (ptr),
    .cpu_rdata (cpu_rdata),
    .ctrl_we   (ctrl_we),
    .data_we   (data_we),
    .cfg_tx    (cfg_tx),
    .cfg_lg    (cfg_lg)
  );

  mf_ptr_ctrl #(.NUM_OBJ(NUM_OBJ)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_tx  (cfg_tx),
    .size_lg  (cfg_lg),
    .obj_ok   (obj_ok),
    .obj_txrq (obj_txrq),
    .rx_valid (rx_valid),
    .tx_done  (tx_done),
    .cpu_busy (cpu_en),
    .ptr_o    (ptr),
    .mask_o   (mask),
    .rx_we    (rx_we),
    .rx_skip  (rx_skip),
    .tx_pend  (tx_pending),
    .tx_fire  (tx_fire)
  );

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
    logic sel_here, rmt_here;
    assign sel_here    = (ptr == PTR_W'(i));
    assign rmt_here    = cfg_tx && rmt_hit && (rmt_idx == PTR_W'(i)) && (rmt_idx <= mask);
    assign obj_ok[i]   = is_valid(ctrl_arr[i].vld);
    assign obj_txrq[i] = ctrl_arr[i].tx_req;

    mf_obj_slot #(.DATA_W(DATA_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_ctrl_we (ctrl_we[i]),
      .cpu_data_we (data_we[i]),
      .cpu_wdata   (cpu_wdata),
      .hw_rx_we    (rx_we && sel_here),
      .hw_rx_data  (rx_data),
      .hw_tx_clr   (tx_fire && sel_here),
      .hw_rmt_set  (rmt_here),
      .ctrl_o      (ctrl_arr[i]),
      .data_o      (data_arr[i])
    );
  end

  assign tx_idx   = ptr;
  assign tx_data  = data_arr[ptr];
  assign fifo_ptr = ptr;

  assert_ptr_in_fifo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ptr & ~mask) == '0);

  assert_skip_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_skip |=> data_arr[$past(ptr)] == $past(data_arr[ptr]));

endmodule

// File: tb/msgfifo_ctrl_test.sv
module msgfifo_ctrl_test;

  localparam int NOBJ = 8;
  localparam int DW   = 16;
  localparam int PW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_en = 1'b0, cpu_we = 1'b0;
  logic [PW+1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          tx_done = 1'b0;
  logic          tx_pending;
  logic [PW-1:0] tx_idx;
  logic [DW-1:0] tx_data;
  logic          rmt_hit = 1'b0;
  logic [PW-1:0] rmt_idx = '0;
  logic [PW-1:0] fifo_ptr;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  msgfifo_ctrl #(.NUM_OBJ(NOBJ), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_done(tx_done), .tx_pending(tx_pending), .tx_idx(tx_idx), .tx_data(tx_data),
    .rmt_hit(rmt_hit), .rmt_idx(rmt_idx), .fifo_ptr(fifo_ptr)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  function automatic logic [PW+1:0] adr(input int idx, input int sel);
    return (PW+2)'(idx * 4 + sel);
  endfunction

  task automatic cpu_wr(input int idx, input int sel, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = adr(idx, sel); cpu_wdata = d;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input int idx, input int sel, output logic [DW-1:0] v);
    @(negedge clk);
    cpu_addr = adr(idx, sel);
    #2 v = cpu_rdata;
  endtask

  task automatic frame(input logic [DW-1:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic remote(input int idx);
    @(negedge clk);
    rmt_hit = 1'b1; rmt_idx = PW'(idx);
    @(negedge clk);
    rmt_hit = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    do_reset();
    check(32'(fifo_ptr), 0, "R1 pointer after reset");
    check(32'(tx_pending), 0, "R1 tx_pending after reset");
    cpu_rd(0, 0, v); check(32'(v), 32'h1, "R1 element 0 control");
    cpu_rd(7, 0, v); check(32'(v), 32'h1, "R1 element 7 control");
    cpu_rd(0, 2, v); check(32'(v), 32'h6, "R1 configuration");
  endtask

  task automatic t_receive();
    logic [DW-1:0] v;
    do_reset();
    cpu_wr(0, 2, 16'h0004);           // receive, size 4
    for (int k = 0; k < 4; k++) cpu_wr(k, 0, 16'h0002);
    for (int k = 0; k < 4; k++) begin
      frame(DW'(16'hA0 + k));
      check(32'(fifo_ptr), 32'((k + 1) % 4), "R2/R3 pointer step and wrap");
    end
    cpu_rd(2, 1, v); check(32'(v), 32'hA2, "R2 element 2 data");
    cpu_rd(2, 0, v); check(32'(v), 32'h6, "R2 element 2 new-data set");
    cpu_rd(4, 0, v); check(32'(v), 32'h1, "R3 element 4 outside FIFO untouched");
    frame(16'hB0);
    cpu_rd(0, 0, v); check(32'(v), 32'hE, "R7 overrun sets lost on element 0");
    cpu_rd(0, 1, v); check(32'(v), 32'hB0, "R7 overrun data");
    cpu_rd(1, 0, v); check(32'(v), 32'h6, "R7 no lost without overrun");
    cpu_wr(3, 0, 16'h0001);
    check(32'(fifo_ptr), 1, "R10 control write keeps pointer");
    cpu_rd(2, 2, v); check(32'(v), 32'h0104, "R10 configuration read shows pointer");
    frame(16'hB1);
    check(32'(fifo_ptr), 2, "R6 invalid element 3 does not block element 1");
    cpu_rd(1, 1, v); check(32'(v), 32'hB1, "R6 element 1 data");
    frame(16'hB2);
    frame(16'hB3);
    check(32'(fifo_ptr), 0, "R5 pointer advances past invalid slave");
    cpu_rd(3, 1, v); check(32'(v), 32'hA3, "R5 invalid slave data kept");
    cpu_rd(3, 0, v); check(32'(v), 32'h1, "R5 invalid slave flags kept");
    cpu_wr(0, 0, 16'h0001);
    frame(16'hC0);
    check(32'(fifo_ptr), 0, "R4 addressed base invalid holds pointer");
    cpu_rd(0, 1, v); check(32'(v), 32'hB0, "R4 addressed base data kept");
    cpu_wr(0, 0, 16'h0002);
    @(negedge clk);                    // CPU clears flags in the same cycle as a frame
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = adr(0, 0); cpu_wdata = 16'h0002;
    rx_valid = 1'b1; rx_data = 16'hC1;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0; rx_valid = 1'b0;
    cpu_rd(0, 0, v); check(32'(v), 32'h6, "R11 new-data wins over CPU clear");
    @(negedge clk);                    // CPU data write collides with a frame
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = adr(1, 1); cpu_wdata = 16'h5555;
    rx_valid = 1'b1; rx_data = 16'hC2;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0; rx_valid = 1'b0;
    cpu_rd(1, 1, v); check(32'(v), 32'hC2, "R11 frame data wins over CPU data");
    check(32'(fifo_ptr), 2, "R11 pointer after collisions");
    cpu_wr(0, 2, 16'h0004);
    check(32'(fifo_ptr), 2, "R10 configuration write keeps pointer");
    cpu_wr(2, 0, 16'h0001);
    cpu_wr(0, 0, 16'h0001);
    frame(16'hD0);
    check(32'(fifo_ptr), 2, "R4 slave and base invalid holds pointer");
    cpu_rd(2, 1, v); check(32'(v), 32'hB2, "R4 slave data kept");
  endtask

  task automatic t_transmit();
    logic [DW-1:0] v;
    do_reset();
    cpu_wr(0, 2, 16'h0005);           // transmit, size 4
    for (int k = 0; k < 4; k++) begin
      cpu_wr(k, 1, DW'(16'h100 + k));
      cpu_wr(k, 0, 16'h0012);
    end
    check(32'(tx_pending), 1, "R8 first element offered");
    check(32'(tx_idx), 0, "R8 transfer starts at element 0");
    for (int k = 0; k < 4; k++) begin
      check(32'(tx_data), 32'h100 + 32'(k), "R8 offered data");
      pulse_done();
      check(32'(fifo_ptr), 32'((k + 1) % 4), "R8 pointer advances on completion");
      cpu_rd(k, 0, v); check(32'(v), 32'h2, "R8 request cleared");
    end
    check(32'(tx_pending), 0, "R8 nothing left to send");
    remote(2);
    cpu_rd(2, 0, v); check(32'(v), 32'h32, "R9 remote sets request and pending");
    check(32'(tx_pending), 0, "R9 request ahead of pointer waits");
    remote(0);
    check(32'(tx_pending), 1, "R9 element 0 requested");
    pulse_done();
    cpu_rd(0, 0, v); check(32'(v), 32'h2, "R8 remote-pending cleared");
    check(32'(fifo_ptr), 1, "R9 pointer after element 0");
    cpu_wr(1, 0, 16'h0011);
    check(32'(tx_pending), 0, "R12 invalid addressed element not offered");
    pulse_done();
    check(32'(fifo_ptr), 1, "R12 done ignored when disabled");
    cpu_rd(1, 0, v); check(32'(v), 32'h11, "R12 flags untouched");
    cpu_wr(1, 0, 16'h0012);
    pulse_done();
    check(32'(tx_idx), 2, "R9 remote element sent in pointer order");
    check(32'(tx_pending), 1, "R9 remote element pending");
    pulse_done();
    cpu_rd(2, 0, v); check(32'(v), 32'h2, "R9 remote element cleared after send");
    check(32'(fifo_ptr), 3, "R9 pointer after remote send");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog (all R): actual hung, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_receive();
    t_transmit();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule